// File: doc/BRIEF.md
# Digital AGC Loop with Sigma-Delta Gain Output

This block closes the gain loop in front of a sampled IF receiver. Each valid signed sample is reduced to its magnitude. The magnitude is taken away from a programmable target level, and the difference is scaled down by an arithmetic right shift. The scaled difference is then added into a saturating gain integrator. The gain word is not driven out in parallel. A first-order sigma-delta modulator turns it into a one-bit pulse stream, and an external RC filter smooths that stream into the amplifier control voltage.

A two-state controller sets the loop bandwidth. In `ST_ACQUIRE` the loop uses a small shift, which gives it a wide bandwidth so it pulls in quickly. The transition `T_SETTLE` moves it to `ST_TRACK` once the absolute error has stayed under a lock threshold for a dwell count of consecutive samples. In `ST_TRACK` a larger shift narrows the bandwidth. The lock output is high in this state, and downstream acquisition logic uses it as its start enable. The transition `T_SLIP` returns the loop to `ST_ACQUIRE` when the error stays above a wider unlock threshold for the same dwell count. The transition `T_RESTART` is taken on a synchronous restart pulse, which a channel change would issue. It forces `ST_ACQUIRE` and clears the dwell counter. The gain integrator keeps running and keeps its value, so the loop converges again from the gain it already holds.

A small write/read register port sets the target level, the two shift amounts, both thresholds and the dwell count. The same port reads back the live gain word.

Top module: `agc_loop`

## Requirements
- R1: After reset, lock is low and the sigma-delta output is 0. The gain reads 2048 (mid-scale of a 12-bit word). The registers read target 256, acquire shift 2, track shift 6, lock threshold 16, unlock threshold 64 and dwell 8.
- R2: Register addresses are: 0 target level, 1 shift pair, 2 lock threshold, 3 unlock threshold, 4 dwell count, 5 gain (read-only). In the shift pair, the acquire shift is at bits [3:0] and the track shift at bits [7:4]. A write takes effect on the next clock, and reading an address returns the value last written to it.
- R3: On each cycle with a valid sample x, the gain changes by (target − |x|) arithmetically shifted right by the active shift. On a cycle with no valid sample the gain does not change.
- R4: The acquire shift is active while lock is low, and the track shift is active while lock is high.
- R5: The gain saturates at 4095 and at 0 and never wraps.
- R6: Lock rises on the clock of the dwell-th consecutive valid sample with |error| < lock threshold. A valid sample that fails the test clears the count. A dwell of 0 acts as 1.
- R7: While locked, lock falls and acquire mode resumes on the clock of the dwell-th consecutive valid sample with |error| > unlock threshold.
- R8: A restart pulse clears lock on the next clock and restarts the dwell count. The gain is not changed.
- R9: With the gain held constant at G, sd_out is 1 on G of every 4096 consecutive clocks (±1).
- R10: The most negative sample, −512, has magnitude 512.
- R11: A write to the gain address (5) changes neither the gain nor any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_valid | input | 1 | Sample strobe |
| samp_data | input | 10 | Signed two's-complement sample |
| restart | input | 1 | Synchronous restart: back to acquire, gain kept |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (write and read) |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for cfg_addr |
| sd_out | output | 1 | One-bit sigma-delta gain stream |
| agc_locked | output | 1 | Lock flag, high in tracking state |

## Verification
The bench drives the gain to both rails and holds it there. An integrator that wraps instead of saturating would show a small value after a full-scale push. It also feeds the sample −512, which a careless absolute value would fold to a wrong magnitude and so a wrong gain step. In the lock tests, one out-of-window sample is placed in the middle of an in-window run. A counter that is not cleared would then lock early. The tests also check that the shift changes with the lock flag, so a swapped shift produces the wrong gain steps. The restart test checks that the lock drops while the gain is kept. Pulse counts over full 4096-clock windows at full scale, zero and mid-scale expose a modulator that takes its carry from the wrong place.

// File: rtl/agc_pkg.sv
package agc_pkg;

    typedef enum logic {
        ST_ACQUIRE = 1'b0,
        ST_TRACK   = 1'b1
    } agc_state_e;

    localparam int CFG_AW = 3;

    localparam logic [CFG_AW-1:0] CFG_TARGET  = 3'd0;
    localparam logic [CFG_AW-1:0] CFG_SHIFTS  = 3'd1;
    localparam logic [CFG_AW-1:0] CFG_LOCKTH  = 3'd2;
    localparam logic [CFG_AW-1:0] CFG_SLIPTH  = 3'd3;
    localparam logic [CFG_AW-1:0] CFG_DWELL   = 3'd4;
    localparam logic [CFG_AW-1:0] CFG_GAIN    = 3'd5;

endpackage

// File: rtl/agc_cfg_regs.sv
module agc_cfg_regs
    import agc_pkg::*;
#(
    parameter int SAMPLE_W  = 10,
    parameter int SHIFT_W   = 4,
    parameter int DWELL_W   = 16,
    parameter int GAIN_W    = 12,
    parameter int CFG_DW    = 16,
    parameter int TGT_RST   = 256,
    parameter int ACQ_RST   = 2,
    parameter int TRK_RST   = 6,
    parameter int LTH_RST   = 16,
    parameter int STH_RST   = 64,
    parameter int DWL_RST   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [CFG_DW-1:0]   cfg_wdata,
    input  logic [GAIN_W-1:0]   gain,
    output logic [SAMPLE_W-1:0] target_lvl,
    output logic [SHIFT_W-1:0]  acq_shift,
    output logic [SHIFT_W-1:0]  trk_shift,
    output logic [SAMPLE_W-1:0] lock_thr,
    output logic [SAMPLE_W-1:0] slip_thr,
    output logic [DWELL_W-1:0]  dwell,
    output logic [CFG_DW-1:0]   cfg_rdata
);

    logic [SAMPLE_W-1:0] tgt_q, lth_q, sth_q;
    logic [SHIFT_W-1:0]  acq_q, trk_q;
    logic [DWELL_W-1:0]  dwl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= SAMPLE_W'(TGT_RST);
            acq_q <= SHIFT_W'(ACQ_RST);
            trk_q <= SHIFT_W'(TRK_RST);
            lth_q <= SAMPLE_W'(LTH_RST);
            sth_q <= SAMPLE_W'(STH_RST);
            dwl_q <= DWELL_W'(DWL_RST);
        end else if (cfg_we) begin
            case (cfg_addr)
                CFG_TARGET: tgt_q <= cfg_wdata[SAMPLE_W-1:0];
                CFG_SHIFTS: begin
                    acq_q <= cfg_wdata[SHIFT_W-1:0];
                    trk_q <= cfg_wdata[2*SHIFT_W-1:SHIFT_W];
                end
                CFG_LOCKTH: lth_q <= cfg_wdata[SAMPLE_W-1:0];
                CFG_SLIPTH: sth_q <= cfg_wdata[SAMPLE_W-1:0];
                CFG_DWELL:  dwl_q <= cfg_wdata[DWELL_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            CFG_TARGET: cfg_rdata[SAMPLE_W-1:0] = tgt_q;
            CFG_SHIFTS: begin
                cfg_rdata[SHIFT_W-1:0]         = acq_q;
                cfg_rdata[2*SHIFT_W-1:SHIFT_W] = trk_q;
            end
            CFG_LOCKTH: cfg_rdata[SAMPLE_W-1:0] = lth_q;
            CFG_SLIPTH: cfg_rdata[SAMPLE_W-1:0] = sth_q;
            CFG_DWELL:  cfg_rdata[DWELL_W-1:0]  = dwl_q;
            CFG_GAIN:   cfg_rdata[GAIN_W-1:0]   = gain;
            default:    cfg_rdata = '0;
        endcase
    end

    assign target_lvl = tgt_q;
    assign acq_shift  = acq_q;
    assign trk_shift  = trk_q;
    assign lock_thr   = lth_q;
    assign slip_thr   = sth_q;
    assign dwell      = dwl_q;

    // R11: a write aimed at the gain address leaves every register alone
    p_gain_ro_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == CFG_GAIN) |=>
            ($stable(tgt_q) && $stable(acq_q) && $stable(trk_q) &&
             $stable(lth_q) && $stable(sth_q) && $stable(dwl_q)));

endmodule

// File: rtl/agc_error_path.sv
module agc_error_path #(
    parameter int SAMPLE_W = 10,
    parameter int SHIFT_W  = 4,
    parameter int GAIN_W   = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       samp_valid,
    input  logic signed [SAMPLE_W-1:0] samp_data,
    input  logic [SAMPLE_W-1:0]        target_lvl,
    input  logic [SHIFT_W-1:0]         shift_amt,
    output logic [SAMPLE_W:0]          err_abs,
    output logic [GAIN_W-1:0]          gain
);

    localparam int ERR_W = SAMPLE_W + 1;
    localparam int SUM_W = ((GAIN_W > ERR_W) ? GAIN_W : ERR_W) + 2;
    localparam logic [GAIN_W-1:0]      GAIN_MID   = GAIN_W'(1) << (GAIN_W - 1);
    localparam logic [GAIN_W-1:0]      GAIN_TOP   = {GAIN_W{1'b1}};
    localparam logic signed [SUM_W-1:0] GAIN_TOP_S = SUM_W'((1 << GAIN_W) - 1);

    logic [SAMPLE_W-1:0]     mag;
    logic signed [ERR_W-1:0] err, err_neg, err_scaled;
    logic signed [SUM_W-1:0] scaled_ext, gain_ext, sum;
    logic [GAIN_W-1:0]       gain_q, gain_d;

    // Unsigned magnitude: -2^(N-1) maps onto 2^(N-1) without folding
    always_comb begin
        if (samp_data[SAMPLE_W-1]) mag = ~samp_data + 1'b1;
        else                       mag = samp_data;
    end

    always_comb begin
        err        = $signed({1'b0, target_lvl}) - $signed({1'b0, mag});
        err_neg    = -err;
        err_abs    = err[ERR_W-1] ? err_neg : err;
        err_scaled = err >>> shift_amt;
        scaled_ext = SUM_W'(err_scaled);
        gain_ext   = $signed({{(SUM_W-GAIN_W){1'b0}}, gain_q});
        sum        = gain_ext + scaled_ext;
    end

    // Saturating integrator
    always_comb begin
        if (sum < 0)               gain_d = '0;
        else if (sum > GAIN_TOP_S) gain_d = GAIN_TOP;
        else                       gain_d = sum[GAIN_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          gain_q <= GAIN_MID;
        else if (samp_valid) gain_q <= gain_d;
    end

    assign gain = gain_q;

    // R3: no sample, no gain movement
    p_gain_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_valid |=> $stable(gain_q));

    // R5: pushing further up from full scale stays at full scale
    p_sat_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && gain_q == GAIN_TOP && err_scaled >= 0) |=> gain_q == GAIN_TOP);

    // R5: pushing further down from zero stays at zero
    p_sat_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && gain_q == '0 && err_scaled <= 0) |=> gain_q == '0);

endmodule

// File: rtl/agc_lock_fsm.sv
module agc_lock_fsm
    import agc_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int DWELL_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                samp_valid,
    input  logic                restart,
    input  logic [SAMPLE_W:0]   err_abs,
    input  logic [SAMPLE_W-1:0] lock_thr,
    input  logic [SAMPLE_W-1:0] slip_thr,
    input  logic [DWELL_W-1:0]  dwell,
    output logic                locked
);

    agc_state_e         state_q, state_d;
    logic [DWELL_W-1:0] cnt_q, cnt_d;
    logic [DWELL_W:0]   cnt_inc;
    logic               inside_win, outside_win, qualify, dwell_hit;

    always_comb begin
        inside_win  = err_abs < {1'b0, lock_thr};
        outside_win = err_abs > {1'b0, slip_thr};
        cnt_inc     = {1'b0, cnt_q} + 1'b1;
        dwell_hit   = cnt_inc >= {1'b0, dwell};
    end

    // Next state and dwell counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        qualify = 1'b0;
        unique case (state_q)
            ST_ACQUIRE: qualify = inside_win;
            ST_TRACK:   qualify = outside_win;
        endcase
        if (restart) begin
            // T_RESTART
            state_d = ST_ACQUIRE;
            cnt_d   = '0;
        end else if (samp_valid) begin
            if (!qualify) begin
                cnt_d = '0;
            end else if (dwell_hit) begin
                cnt_d = '0;
                unique case (state_q)
                    ST_ACQUIRE: state_d = ST_TRACK;    // T_SETTLE
                    ST_TRACK:   state_d = ST_ACQUIRE;  // T_SLIP
                endcase
            end else begin
                cnt_d = cnt_inc[DWELL_W-1:0];
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACQUIRE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        locked = (state_q == ST_TRACK);
    end

    // R6: lock only rises after an in-window sample
    p_lock_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(samp_valid && inside_win && !restart));

    // R7: lock only falls on restart or an out-of-window sample
    p_lock_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(restart || (samp_valid && outside_win)));

    // R8: restart always clears lock
    p_restart_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !locked);

endmodule

// File: rtl/agc_sigma_delta.sv
module agc_sigma_delta #(
    parameter int GAIN_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GAIN_W-1:0] gain,
    output logic              sd_bit
);

    logic [GAIN_W-1:0] acc_q;
    logic [GAIN_W:0]   acc_sum;
    logic              sd_q;

    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, gain};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            sd_q  <= 1'b0;
        end else begin
            acc_q <= acc_sum[GAIN_W-1:0];
            sd_q  <= acc_sum[GAIN_W];
        end
    end

    assign sd_bit = sd_q;

    // R9: zero gain gives no pulses
    p_sd_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gain == '0) |=> !sd_bit);

endmodule

// File: rtl/agc_loop.sv
module agc_loop
    import agc_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int SHIFT_W  = 4,
    parameter int DWELL_W  = 16,
    parameter int GAIN_W   = 12,
    parameter int CFG_DW   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       samp_valid,
    input  logic signed [SAMPLE_W-1:0] samp_data,
    input  logic                       restart,
    input  logic                       cfg_we,
    input  logic [CFG_AW-1:0]          cfg_addr,
    input  logic [CFG_DW-1:0]          cfg_wdata,
    output logic [CFG_DW-1:0]          cfg_rdata,
    output logic                       sd_out,
    output logic                       agc_locked
);

    logic [SAMPLE_W-1:0] target_lvl, lock_thr, slip_thr;
    logic [SHIFT_W-1:0]  acq_shift, trk_shift, shift_sel;
    logic [DWELL_W-1:0]  dwell;
    logic [SAMPLE_W:0]   err_abs;
    logic [GAIN_W-1:0]   gain;
    logic                locked;

    agc_cfg_regs #(
        .SAMPLE_W(SAMPLE_W), .SHIFT_W(SHIFT_W), .DWELL_W(DWELL_W),
        .GAIN_W(GAIN_W), .CFG_DW(CFG_DW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .gain(gain), .target_lvl(target_lvl),
        .acq_shift(acq_shift), .trk_shift(trk_shift), .lock_thr(lock_thr),
        .slip_thr(slip_thr), .dwell(dwell), .cfg_rdata(cfg_rdata)
    );

    // Bandwidth select follows the lock state
    assign shift_sel = locked ? trk_shift : acq_shift;

    agc_error_path #(
        .SAMPLE_W(SAMPLE_W), .SHIFT_W(SHIFT_W), .GAIN_W(GAIN_W)
    ) u_err (
        .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_data(samp_data),
        .target_lvl(target_lvl), .shift_amt(shift_sel), .err_abs(err_abs), .gain(gain)
    );

    agc_lock_fsm #(
        .SAMPLE_W(SAMPLE_W), .DWELL_W(DWELL_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .restart(restart),
        .err_abs(err_abs), .lock_thr(lock_thr), .slip_thr(slip_thr),
        .dwell(dwell), .locked(locked)
    );

    agc_sigma_delta #(
        .GAIN_W(GAIN_W)
    ) u_sd (
        .clk(clk), .rst_n(rst_n), .gain(gain), .sd_bit(sd_out)
    );

    assign agc_locked = locked;

    // R8: restart without a sample keeps the gain
    p_restart_keeps_gain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !samp_valid) |=> $stable(gain));

endmodule

// File: tb/tb_agc_loop.sv
module tb_agc_loop;
    import agc_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              samp_valid = 1'b0;
    logic signed [9:0] samp_data = '0;
    logic              restart = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_addr = CFG_GAIN;
    logic [15:0]       cfg_wdata = '0;
    logic [15:0]       cfg_rdata;
    logic              sd_out;
    logic              agc_locked;

    always #2 clk = ~clk;

    agc_loop dut (
        .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_data(samp_data),
        .restart(restart), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .sd_out(sd_out), .agc_locked(agc_locked)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    typedef struct {
        int    gain;
        bit    lock;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    // Reference model state
    int m_tgt = 256, m_acq = 2, m_trk = 6, m_lth = 16, m_sth = 64, m_dwl = 8;
    int m_gain = 2048, m_cnt = 0;
    bit m_lock = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Driver: one valid sample, expectation pushed after the capturing edge
    task automatic send(input int x, input string tag);
        int mag, err, aerr, sh, nxt, lim;
        bit qual;
        exp_t e;
        @(negedge clk);
        samp_valid = 1'b1;
        samp_data  = 10'(x);
        mag  = (x < 0) ? -x : x;
        err  = m_tgt - mag;
        aerr = (err < 0) ? -err : err;
        sh   = m_lock ? m_trk : m_acq;
        nxt  = m_gain + (err >>> sh);
        if (nxt < 0) nxt = 0;
        if (nxt > 4095) nxt = 4095;
        m_gain = nxt;
        qual = m_lock ? (aerr > m_sth) : (aerr < m_lth);
        lim  = (m_dwl == 0) ? 1 : m_dwl;
        if (qual) begin
            m_cnt++;
            if (m_cnt >= lim) begin
                m_lock = !m_lock;
                m_cnt  = 0;
            end
        end else begin
            m_cnt = 0;
        end
        @(posedge clk);
        #1;
        e.gain = m_gain; e.lock = m_lock; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            samp_valid = 1'b0;
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        samp_valid = 1'b0;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = CFG_GAIN;
    endtask

    task automatic rd_check(input logic [2:0] a, input int exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(int'(cfg_rdata) == exp, tag, int'(cfg_rdata), exp);
        cfg_addr = CFG_GAIN;
    endtask

    task automatic sd_window(input string tag);
        int ones = 0;
        idle(8);
        repeat (4096) begin
            @(negedge clk);
            ones += int'(sd_out);
        end
        check((ones >= m_gain - 1) && (ones <= m_gain + 1), tag, ones, m_gain);
    endtask

    // Monitor: compare each sample's result on the next falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(int'(cfg_rdata) == e.gain, {e.tag, " gain"}, int'(cfg_rdata), e.gain);
            check(agc_locked == e.lock, {e.tag, " lock"}, int'(agc_locked), int'(e.lock));
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            report();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(agc_locked == 1'b0, "R1 lock", int'(agc_locked), 0);
        check(sd_out == 1'b0, "R1 sd_out", int'(sd_out), 0);
        rd_check(CFG_GAIN,   2048, "R1 gain");
        rd_check(CFG_TARGET, 256,  "R1 target");
        rd_check(CFG_SHIFTS, 'h62, "R1 shifts");
        rd_check(CFG_LOCKTH, 16,   "R1 lock thr");
        rd_check(CFG_SLIPTH, 64,   "R1 slip thr");
        rd_check(CFG_DWELL,  8,    "R1 dwell");

        // R2 configuration write and readback
        wr(CFG_SHIFTS, 'h52); m_acq = 2; m_trk = 5;
        wr(CFG_LOCKTH, 20);   m_lth = 20;
        wr(CFG_SLIPTH, 80);   m_sth = 80;
        wr(CFG_DWELL,  6);    m_dwl = 6;
        wr(CFG_TARGET, 300);
        rd_check(CFG_TARGET, 300, "R2 target");
        wr(CFG_TARGET, 256);
        rd_check(CFG_SHIFTS, 'h52, "R2 shifts");
        rd_check(CFG_LOCKTH, 20,   "R2 lock thr");
        rd_check(CFG_SLIPTH, 80,   "R2 slip thr");
        rd_check(CFG_DWELL,  6,    "R2 dwell");
        rd_check(CFG_TARGET, 256,  "R2 target back");

        // R3/R4 low-level input in acquire: gain climbs with acquire shift
        for (int i = 0; i < 10; i++) send((i % 2) ? -100 : 100, "R3 R4 acquire step");
        idle(3);
        rd_check(CFG_GAIN, m_gain, "R3 hold without samples");

        // R6 interrupted run, then a full run that locks
        for (int i = 0; i < 4; i++) send((i % 2) ? -256 : 256, "R6 partial run");
        send(0, "R6 run broken");
        for (int i = 0; i < 6; i++) send((i % 2) ? -250 : 250, "R6 full run");
        idle(2);
        check(agc_locked == 1'b1, "R6 locked after dwell", int'(agc_locked), 1);

        // R4 track shift while locked
        for (int i = 0; i < 4; i++) send((i % 2) ? -300 : 300, "R4 track step");

        // R7 R10 full-scale negative samples pull out of lock
        for (int i = 0; i < 6; i++) send(-512, "R7 R10 slip");
        idle(2);
        check(agc_locked == 1'b0, "R7 unlocked", int'(agc_locked), 0);

        // R8 relock then restart
        for (int i = 0; i < 6; i++) send((i % 2) ? -256 : 256, "R8 relock");
        idle(2);
        check(agc_locked == 1'b1, "R8 locked before restart", int'(agc_locked), 1);
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        m_lock = 0; m_cnt = 0;
        check(agc_locked == 1'b0, "R8 restart clears lock", int'(agc_locked), 0);
        rd_check(CFG_GAIN, m_gain, "R8 gain kept");
        send(256, "R8 count restarted");

        // R11 write to gain address ignored
        idle(2);
        wr(CFG_GAIN, 'h0123);
        rd_check(CFG_GAIN,   m_gain, "R11 gain unchanged");
        rd_check(CFG_TARGET, 256,    "R11 target unchanged");
        rd_check(CFG_SHIFTS, 'h52,   "R11 shifts unchanged");

        // R5 saturate high, then R9 density at full scale
        wr(CFG_SHIFTS, 'h00); m_acq = 0; m_trk = 0;
        for (int i = 0; i < 12; i++) send(0, "R5 push high");
        idle(2);
        rd_check(CFG_GAIN, 4095, "R5 saturated high");
        sd_window("R9 density full scale");

        // R5 saturate low with target 0 and -512 input (R10)
        wr(CFG_TARGET, 0); m_tgt = 0;
        for (int i = 0; i < 12; i++) send(-512, "R5 R10 push low");
        idle(2);
        rd_check(CFG_GAIN, 0, "R5 saturated low");
        sd_window("R9 density zero");

        // R9 mid-scale density
        wr(CFG_TARGET, 256); m_tgt = 256;
        for (int i = 0; i < 10; i++) send((i % 2) ? -100 : 100, "R3 mid ramp");
        idle(2);
        sd_window("R9 density mid");

        idle(4);
        done = 1;
        report();
        $finish;
    end

endmodule